// File: doc/BRIEF.md
# Fractional Baud Generator

This block divides a system clock down to the 16x oversampling tick that a UART transmitter and receiver run on. Every bit time is split into sixteen sub-periods. Each sub-period is the integer divisor plus one clock long. A 16-bit slot mask can add one clock to any chosen sub-periods. Setting some mask bits makes the mean sub-period length fall between two integers, so the bit rate can follow a divisor with a fractional part.

Software works out the divisor as the input clock divided by sixteen times the baud rate, minus one, and drops the fraction. The fractional part, times sixteen and truncated, gives an index from 0 to 15. The package maps that index to a mask with exactly that many bits set, and the bits are spread evenly. Both values are written through a one-cycle write port. They move into the live counter only on a tick boundary, so a reprogram never cuts a sub-period short. The block outputs the tick pulse and the number of the sub-period that the pulse closes.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, the slot index is 0 and a new sub-period starts. The live divisor is loaded with `RST_DIV` and the live mask with the table mask for `RST_FRAC`. The first tick comes in the (`RST_DIV`+1)-th clock after the cycle in which reset is released, counting that cycle as the first.
- R2: The sub-period with slot index k lasts divisor+1 clocks when mask bit k is 0 and divisor+2 clocks when it is 1.
- R3: The tick is high for the last clock of each sub-period only. The slot index names the current sub-period. It goes up by one on the clock after each tick and wraps from 15 to 0.
- R4: Any sixteen consecutive sub-periods that start at slot 0 last 16×(divisor+1) plus the number of set mask bits, counted in clocks.
- R5: A write with `wr_sel`=0 stores `wr_data` as the divisor, and a write with `wr_sel`=1 stores it as the slot mask. Mask bit 0 belongs to slot 0 and bit 15 to slot 15.
- R6: A write takes effect at the next tick boundary, and the sub-period in progress keeps its old length. A write made in the same cycle as a tick applies to the sub-period that starts right after that tick.
- R7: When `wr_en` is low, `wr_sel` and `wr_data` have no effect on any sub-period length.
- R8: Divisor 0xFFFF gives sub-periods of 65536 or 65537 clocks without the counter wrapping. Divisor 0 with an empty mask gives a tick on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the configuration values |
| wr_sel | input | 1 | Target of the write: 0 divisor, 1 slot mask |
| wr_data | input | 16 | Value written |
| tick | output | 1 | Oversample tick, high for one clock at the end of a sub-period |
| slot_idx | output | 4 | Number of the current sub-period within the bit time |

## Verification
A wrong divisor or a wrong mask bit shows up at the ports at the very next tick, as a gap between ticks that is one or more clocks off for that slot number. A slot counter that slips or fails to wrap puts the extra clock on the wrong sub-period. It also shows an out-of-order index on the first tick after the fault. A configuration that moves into the live registers mid-period changes the length of the period already in progress, and that is seen one tick later. A counter that does not restart at a tick shows at once as a missing or longer-than-allowed interval.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DIV_W  = 16;
    localparam int SLOT_N = 16;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int CNT_W  = DIV_W + 1;
    localparam int DATA_W = (DIV_W > SLOT_N) ? DIV_W : SLOT_N;

    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [SLOT_N-1:0] mask_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        REG_DIV  = 1'b0,
        REG_MASK = 1'b1
    } reg_sel_e;

    typedef struct packed {
        div_t  div;
        mask_t mask;
    } rate_cfg_t;

    // Final count value of a sub-period: the count runs 0..limit.
    function automatic cnt_t period_limit(div_t d, logic extra);
        return cnt_t'(d) + cnt_t'(extra);
    endfunction

    // Evenly spread mask holding as many set bits as the fraction index.
    function automatic mask_t frac_to_mask(logic [3:0] idx);
        case (idx)
            4'd0:    return mask_t'(16'h0000);
            4'd1:    return mask_t'(16'h0080);
            4'd2:    return mask_t'(16'h0808);
            4'd3:    return mask_t'(16'h0888);
            4'd4:    return mask_t'(16'h2222);
            4'd5:    return mask_t'(16'h4924);
            4'd6:    return mask_t'(16'h4a52);
            4'd7:    return mask_t'(16'h54aa);
            4'd8:    return mask_t'(16'h5555);
            4'd9:    return mask_t'(16'hd555);
            4'd10:   return mask_t'(16'hd5d5);
            4'd11:   return mask_t'(16'hddd5);
            4'd12:   return mask_t'(16'hdddd);
            4'd13:   return mask_t'(16'hdfdd);
            4'd14:   return mask_t'(16'hdfdf);
            default: return mask_t'(16'hffdf);
        endcase
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter rate_cfg_t RST_CFG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output rate_cfg_t         act
);

    rate_cfg_t stage_q;
    rate_cfg_t stage_d;
    rate_cfg_t act_q;

    always_comb begin
        stage_d = stage_q;
        if (wr_en) begin
            if (reg_sel_e'(wr_sel) == REG_MASK) begin
                stage_d.mask = mask_t'(wr_data);
            end else begin
                stage_d.div = div_t'(wr_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RST_CFG;
            act_q   <= RST_CFG;
        end else begin
            stage_q <= stage_d;
            if (load) begin
                act_q <= stage_d;
            end
        end
    end

    assign act = act_q;

endmodule

// File: rtl/baud_period_ctr.sv
module baud_period_ctr
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t limit,
    output logic tick,
    output cnt_t cnt
);

    cnt_t cnt_q;

    assign tick = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/baud_slot_seq.sv
module baud_slot_seq
    import baud_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output slot_t slot
);

    localparam slot_t LAST = slot_t'(SLOT_N - 1);

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (adv) begin
            slot_q <= (slot_q == LAST) ? '0 : slot_q + slot_t'(1);
        end
    end

    assign slot = slot_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter logic [15:0] RST_DIV  = 16'd3,
    parameter logic [3:0]  RST_FRAC = 4'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick,
    output logic [SLOT_W-1:0] slot_idx
);

    localparam rate_cfg_t RST_CFG = '{div: div_t'(RST_DIV), mask: frac_to_mask(RST_FRAC)};

    rate_cfg_t act;
    cnt_t      cnt_q;
    cnt_t      limit;
    logic      extra;

    baud_cfg_regs #(
        .RST_CFG (RST_CFG)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (tick),
        .act     (act)
    );

    assign extra = act.mask[slot_idx];
    assign limit = period_limit(act.div, extra);

    baud_period_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .limit (limit),
        .tick  (tick),
        .cnt   (cnt_q)
    );

    baud_slot_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .adv  (tick),
        .slot (slot_idx)
    );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk
    import baud_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick,
    input slot_t     slot_idx,
    input cnt_t      cnt,
    input rate_cfg_t act
);

    // R1: first cycle out of reset starts slot 0 at count 0
    a_r1_reset_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (slot_idx == '0 && cnt == '0));

    // R2: the count never runs past divisor+1
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= cnt_t'(act.div) + cnt_t'(1));

    // R3: a tick restarts the count, otherwise it climbs by one
    a_r3_tick_restart: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == '0);

    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        !tick |=> cnt == cnt_t'($past(cnt) + cnt_t'(1)));

    // R3: slot index moves only on a tick, by one, wrapping
    a_r3_slot_advance: assert property (@(posedge clk) disable iff (rst)
        tick |=> slot_idx == slot_t'($past(slot_idx) + slot_t'(1)));

    a_r3_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slot_idx));

    // R6: live configuration changes only at a tick boundary
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act));

endmodule

bind frac_baud_gen frac_baud_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .slot_idx (slot_idx),
    .cnt      (cnt_q),
    .act      (act)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_sel;
    logic [15:0] wr_data;
    logic        tick;
    logic [3:0]  slot_idx;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    frac_baud_gen dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tick     (tick),
        .slot_idx (slot_idx)
    );

    // {divisor, mask, expected clocks over 16 sub-periods}
    localparam logic [47:0] VECS [8] = '{
        {16'd0, 16'h0000, 16'd16},
        {16'd1, 16'h0080, 16'd33},
        {16'd2, 16'h0888, 16'd51},
        {16'd3, 16'h4924, 16'd69},
        {16'd5, 16'h5555, 16'd104},
        {16'd7, 16'hdfdf, 16'd142},
        {16'd0, 16'hffdf, 16'd31},
        {16'd9, 16'hd5d5, 16'd170}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [15:0] d, input logic [15:0] m, input logic [3:0] s);
        return int'(d) + 1 + int'(m[s]);
    endfunction

    // Counts negedges until one that sees a tick.
    task automatic next_tick(output int n, output logic [3:0] s);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick);
        s = slot_idx;
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        summary();
    end

    initial begin
        int          n;
        int          m;
        int          total;
        logic [3:0]  s;
        logic [15:0] d;
        logic [15:0] k;

        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and first tick after RST_DIV more clocks
        chk(tick == 1'b0, "R1 tick", tick, 0);
        chk(slot_idx == 4'd0, "R1 slot", slot_idx, 0);
        next_tick(n, s);
        chk(n == 3, "R1 first period", n, 3);
        chk(s == 4'd0, "R1 first slot", s, 0);

        // R7: port toggling without wr_en leaves periods at 4
        wr_sel  = 1'b1;
        wr_data = 16'hffff;
        for (int i = 0; i < 3; i++) begin
            next_tick(n, s);
            wr_sel  = ~wr_sel;
            wr_data = ~wr_data;
            chk(n == 4, "R7 ignored write", n, 4);
        end
        wr_sel  = 1'b0;
        wr_data = '0;

        // Vector table: R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            d = VECS[v][47:32];
            k = VECS[v][31:16];
            wr(1'b0, d);
            wr(1'b1, k);
            next_tick(n, s);
            do next_tick(n, s); while (s != 4'd15);
            total = 0;
            for (int j = 0; j < 16; j++) begin
                next_tick(n, s);
                total += n;
                chk(s == 4'(j), "R3 slot order", s, j);
                chk(n == exp_len(d, k, s), "R2 R5 period", n, exp_len(d, k, s));
            end
            chk(total == int'(VECS[v][15:0]), (d == 16'd0 && k == 16'd0) ? "R4 R8 total" : "R4 total",
                total, int'(VECS[v][15:0]));
        end

        // R6: mid-period write keeps current length
        wr(1'b0, 16'd4);
        wr(1'b1, 16'h0000);
        next_tick(n, s);
        next_tick(n, s);
        chk(n == 5, "R6 baseline", n, 5);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 1'b0;
        wr_data = 16'd10;
        @(negedge clk);
        wr_en   = 1'b0;
        next_tick(m, s);
        chk(m + 2 == 5, "R6 period in progress", m + 2, 5);
        next_tick(n, s);
        chk(n == 11, "R6 next period", n, 11);

        // R6: write in the tick cycle applies right after it
        wr_en   = 1'b1;
        wr_data = 16'd2;
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        if (!tick) begin
            next_tick(m, s);
            n += m;
        end
        chk(n == 3, "R6 tick-cycle write", n, 3);

        // R8: maximum divisor
        wr(1'b0, 16'hffff);
        wr(1'b1, 16'h0001);
        next_tick(n, s);
        next_tick(n, s);
        chk(n == exp_len(16'hffff, 16'h0001, s), "R8 max divisor", n, exp_len(16'hffff, 16'h0001, s));
        wr_en   = 1'b1;
        wr_sel  = 1'b0;
        wr_data = 16'd2;
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        if (!tick) begin
            next_tick(m, s);
            n += m;
        end
        chk(n == exp_len(16'd2, 16'h0001, s), "R8 return from max", n, exp_len(16'd2, 16'h0001, s));

        summary();
    end

endmodule